// File: doc/BRIEF.md
# Serial Character Transmitter with Programmable Baud Divisor

This block is the sending half of an asynchronous serial port. A 16-bit divisor sets how many system clock cycles make one oversampling tick. Sixteen ticks make one bit time, so a divisor N gives a bit rate of f_clk / (16 × N). A divisor of zero stops the tick entirely, and any frame in flight freezes on its current bit.

Software-side logic hands over one character at a time through a single-entry holding register. The holding register feeds a shift register that sends the frame. A frame is a low start bit, eight data bits least significant first, an optional parity bit, and a high stop bit. The ready flag rises as soon as the holding register is free again, so the next character can be queued while the current frame is still on the line. The empty flag is high only when nothing is held and nothing is being sent. Two one-cycle control inputs turn the transmitter off (aborting any frame and discarding the held character) or on.

Top module: `serial_tx_core`

## Requirements
- R1: After reset the line `txd` is high, and `hold_ready` and `tx_empty` are both low, because the transmitter starts disabled.
- R2: A one-cycle `tx_enable` pulse on a disabled transmitter makes `hold_ready` and `tx_empty` high from the next cycle on.
- R3: The line idles high. A frame is a low start bit, then `wr_data` bit 0 first through bit 7, then an optional parity bit, then a high stop bit.
- R4: With divisor N ≥ 1, every bit of a frame holds for exactly 16·N clock cycles. The first bit begins the cycle after the character leaves the holding register.
- R5: While `div_val` is 0 no tick occurs, so `txd` keeps its level and a frame in progress does not advance. Writing a nonzero divisor resumes it.
- R6: `par_sel` encodes the parity bit: 3'b000 even (total of ones in data plus parity is even), 3'b001 odd, 3'b010 always 0, 3'b011 always 1, and any value 3'b1xx omits the parity bit, giving a 10-bit frame. The mode is captured when the character enters the shift register.
- R7: A write is accepted when `wr_valid` and `hold_ready` are both high. The character moves to the shift register one cycle later if the shifter is idle or finishing its stop bit. `hold_ready` is high again from that cycle, and a queued character follows the previous stop bit with no idle gap.
- R8: `tx_empty` is high only when the holding register and the shift register are both idle. It goes high the cycle after the last stop-bit period ends.
- R9: A write while `hold_ready` is low, including while the transmitter is disabled, is ignored: the held character is unchanged and nothing extra is sent.
- R10: A `tx_reset` pulse aborts any frame, drops the held character and disables the transmitter. From the next cycle `txd` is high and both flags are low. `tx_reset` takes precedence over a simultaneous `tx_enable`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | 16 | Baud divisor; 0 stops the tick |
| par_sel | input | 3 | Parity mode selector (see R6) |
| tx_reset | input | 1 | One-cycle pulse: abort and disable |
| tx_enable | input | 1 | One-cycle pulse: enable |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line output |
| hold_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Holding and shift registers both idle |

## Verification
The following properties are checked on every cycle:
- an empty transmitter keeps the line high and reports ready;
- a reset pulse leaves the block disabled with an idle line;
- a rejected write leaves the held character untouched;
- a character moving into the shifter frees the holding register;
- a zero divisor freezes the line level.

The exact bit order, the parity value for each mode, the 16·N bit duration and the gapless chaining of two queued characters can only be shown by the bench capturing whole frames at bit centres. The same holds for a frozen frame resuming after the divisor returns and an aborted frame never reappearing after re-enable.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

   localparam int PAR_SEL_W = 3;

   typedef enum logic [1:0] {
      PK_EVEN  = 2'b00,
      PK_ODD   = 2'b01,
      PK_SPACE = 2'b10,
      PK_MARK  = 2'b11
   } par_kind_e;

   function automatic logic parity_bit(input par_kind_e kind, input logic ones_odd);
      logic b;
      case (kind)
         PK_EVEN:  b = ones_odd;
         PK_ODD:   b = ~ones_odd;
         PK_SPACE: b = 1'b0;
         default:  b = 1'b1;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/sertx_baud_gen.sv
`timescale 1ns/1ps
module sertx_baud_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             restart,
   output logic             tick
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] cnt_q;
   logic             halted;
   logic             at_end;

   assign halted = (div == '0);
   assign at_end = (cnt_q >= div - ONE);
   assign tick   = !halted && (cnt_q == div - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || halted || at_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + ONE;
      end
   end
endmodule

// File: rtl/sertx_hold.sv
`timescale 1ns/1ps
module sertx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_acc,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (flush) begin
         full <= 1'b0;
      end else if (wr_acc) begin
         full <= 1'b1;
         data <= wr_data;
      end else if (take) begin
         full <= 1'b0;
      end
   end
endmodule

// File: rtl/sertx_shifter.sv
`timescale 1ns/1ps
module sertx_shifter
   import sertx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 abort,
   input  logic                 load,
   input  logic [DATA_W-1:0]    data,
   input  logic [PAR_SEL_W-1:0] par_sel,
   input  logic                 tick,
   output logic                 busy,
   output logic                 done,
   output logic                 txd
);
   localparam int FRAME_W = DATA_W + 3;
   localparam int IDX_W   = $clog2(FRAME_W);
   localparam int SUB_W   = (OVS > 1) ? $clog2(OVS) : 1;

   logic [FRAME_W-1:0] sh_q;
   logic [FRAME_W-1:0] frame_d;
   logic [IDX_W-1:0]   idx_q;
   logic [IDX_W-1:0]   last_q;
   logic [IDX_W-1:0]   last_d;
   logic               par_b;
   logic               no_par;
   logic               bit_end;

   assign no_par  = par_sel[PAR_SEL_W-1];
   assign par_b   = no_par ? 1'b1 : parity_bit(par_kind_e'(par_sel[1:0]), ^data);
   // Without parity the parity slot carries the stop level and the frame is one bit shorter.
   assign frame_d = {1'b1, par_b, data, 1'b0};
   assign last_d  = no_par ? IDX_W'(FRAME_W - 2) : IDX_W'(FRAME_W - 1);

   generate
      if (OVS == 1) begin : g_sub_none
         assign bit_end = tick;
      end else begin : g_sub_cnt
         logic [SUB_W-1:0] sub_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sub_q <= '0;
            end else if (abort || load) begin
               sub_q <= '0;
            end else if (busy && tick) begin
               sub_q <= (sub_q == SUB_W'(OVS - 1)) ? '0 : sub_q + SUB_W'(1);
            end
         end
         assign bit_end = tick && (sub_q == SUB_W'(OVS - 1));
      end
   endgenerate

   assign done = busy && bit_end && (idx_q == last_q);
   assign txd  = busy ? sh_q[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         sh_q   <= '1;
         idx_q  <= '0;
         last_q <= '0;
      end else if (abort) begin
         busy <= 1'b0;
      end else if (load) begin
         busy   <= 1'b1;
         sh_q   <= frame_d;
         idx_q  <= '0;
         last_q <= last_d;
      end else if (busy && bit_end) begin
         sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
         idx_q <= idx_q + IDX_W'(1);
         if (idx_q == last_q) begin
            busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/serial_tx_core.sv
`timescale 1ns/1ps
module serial_tx_core
   import sertx_pkg::*;
#(
   parameter int DIV_W  = 16,
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DIV_W-1:0]     div_val,
   input  logic [PAR_SEL_W-1:0] par_sel,
   input  logic                 tx_reset,
   input  logic                 tx_enable,
   input  logic                 wr_valid,
   input  logic [DATA_W-1:0]    wr_data,
   output logic                 txd,
   output logic                 hold_ready,
   output logic                 tx_empty
);
   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (OVS < 1) begin : g_bad_ovs
         $error("OVS must be at least 1");
      end
   endgenerate

   logic              enabled_q;
   logic              hold_full;
   logic [DATA_W-1:0] hold_q;
   logic              wr_acc;
   logic              load_w;
   logic              tick_w;
   logic              sh_busy;
   logic              sh_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enabled_q <= 1'b0;
      end else if (tx_reset) begin
         enabled_q <= 1'b0;
      end else if (tx_enable) begin
         enabled_q <= 1'b1;
      end
   end

   assign hold_ready = enabled_q && !hold_full;
   assign tx_empty   = enabled_q && !hold_full && !sh_busy;
   assign wr_acc     = wr_valid && hold_ready && !tx_reset;
   assign load_w     = enabled_q && !tx_reset && hold_full && (!sh_busy || sh_done);

   sertx_baud_gen #(.DIV_W(DIV_W)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .div     (div_val),
      .restart (load_w),
      .tick    (tick_w)
   );

   sertx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (tx_reset),
      .wr_acc  (wr_acc),
      .wr_data (wr_data),
      .take    (load_w),
      .full    (hold_full),
      .data    (hold_q)
   );

   sertx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .abort   (tx_reset),
      .load    (load_w),
      .data    (hold_q),
      .par_sel (par_sel),
      .tick    (tick_w),
      .busy    (sh_busy),
      .done    (sh_done),
      .txd     (txd)
   );
endmodule

// File: rtl/serial_tx_checker.sv
`timescale 1ns/1ps
module serial_tx_checker #(
   parameter int DIV_W  = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_reset,
   input logic              wr_valid,
   input logic [DIV_W-1:0]  div_val,
   input logic              txd,
   input logic              hold_ready,
   input logic              tx_empty,
   input logic              load,
   input logic [DATA_W-1:0] hold_data
);
   // R3
   idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> txd);

   // R8
   empty_means_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> hold_ready);

   // R10
   reset_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_reset |=> (!hold_ready && !tx_empty && txd));

   // R9
   rejected_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !hold_ready) |=> $stable(hold_data));

   // R7
   ready_after_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !tx_reset) |=> hold_ready);

   // R5
   zero_div_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_val == '0 && !load && !tx_reset) |=> $stable(txd));
endmodule

bind serial_tx_core serial_tx_checker #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_reset   (tx_reset),
   .wr_valid   (wr_valid),
   .div_val    (div_val),
   .txd        (txd),
   .hold_ready (hold_ready),
   .tx_empty   (tx_empty),
   .load       (load_w),
   .hold_data  (hold_q)
);

// File: tb/test_serial_tx_core.sv
`timescale 1ns/1ps
module test_serial_tx_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] div_val = 16'd1;
   logic [2:0]  par_sel = 3'b100;
   logic        tx_reset = 1'b0;
   logic        tx_enable = 1'b0;
   logic        wr_valid = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic        txd;
   logic        hold_ready;
   logic        tx_empty;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   serial_tx_core i_serial_tx_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .div_val    (div_val),
      .par_sel    (par_sel),
      .tx_reset   (tx_reset),
      .tx_enable  (tx_enable),
      .wr_valid   (wr_valid),
      .wr_data    (wr_data),
      .txd        (txd),
      .hold_ready (hold_ready),
      .tx_empty   (tx_empty)
   );

   // {divisor, parity select, data, parity present, expected parity bit}
   localparam logic [28:0] VEC [8] = '{
      {16'd1, 3'b000, 8'hA5, 1'b1, 1'b0},
      {16'd2, 3'b001, 8'h3C, 1'b1, 1'b1},
      {16'd3, 3'b010, 8'hFF, 1'b1, 1'b0},
      {16'd1, 3'b011, 8'h00, 1'b1, 1'b1},
      {16'd2, 3'b100, 8'h81, 1'b0, 1'b0},
      {16'd1, 3'b111, 8'h7E, 1'b0, 1'b0},
      {16'd1, 3'b000, 8'h01, 1'b1, 1'b1},
      {16'd4, 3'b001, 8'h80, 1'b1, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic pulse_ctrl(input logic rst_v, input logic en_v);
      @(negedge clk);
      tx_reset  = rst_v;
      tx_enable = en_v;
      @(negedge clk);
      tx_reset  = 1'b0;
      tx_enable = 1'b0;
   endtask

   task automatic count_lows(input int n, output int lows);
      lows = 0;
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         if (txd == 1'b0) lows++;
      end
   endtask

   task automatic run_frame(input int n, input logic [7:0] d, input int len, input logic [10:0] exp);
      logic [10:0] cap = '0;
      @(negedge clk); wr_valid = 1'b1; wr_data = d;
      @(negedge clk); wr_valid = 1'b0;
      @(posedge clk); #1;
      check("R7 ready once character moved", {31'd0, hold_ready}, 32'd1);
      repeat (8 * n) @(posedge clk);
      #1; cap[0] = txd;
      for (int j = 1; j < len; j++) begin
         repeat (16 * n) @(posedge clk);
         #1; cap[j] = txd;
      end
      check("R3/R6 frame bits", {21'd0, cap}, {21'd0, exp});
      repeat (8 * n - 1) @(posedge clk);
      #1;
      check("R4 frame still busy at last cycle", {31'd0, tx_empty}, 32'd0);
      @(posedge clk); #1;
      check("R8 empty after stop bit", {31'd0, tx_empty}, 32'd1);
      check("R3 line idle high", {31'd0, txd}, 32'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int lows;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      // R1
      check("R1 txd after reset", {31'd0, txd}, 32'd1);
      check("R1 ready after reset", {31'd0, hold_ready}, 32'd0);
      check("R1 empty after reset", {31'd0, tx_empty}, 32'd0);

      // R9: write while disabled is dropped
      @(negedge clk); wr_valid = 1'b1; wr_data = 8'h00;
      @(negedge clk); wr_valid = 1'b0;
      pulse_ctrl(1'b0, 1'b1);
      #1;
      // R2
      check("R2 ready after enable", {31'd0, hold_ready}, 32'd1);
      check("R2 empty after enable", {31'd0, tx_empty}, 32'd1);
      count_lows(200, lows);
      check("R9 disabled write not sent", lows, 32'd0);

      // Table walk: R3 R4 R6 R7 R8
      for (int i = 0; i < 8; i++) begin
         logic [10:0] exp;
         int len;
         @(negedge clk);
         div_val = VEC[i][28:13];
         par_sel = VEC[i][12:10];
         if (VEC[i][1]) begin
            exp = {1'b1, VEC[i][0], VEC[i][9:2], 1'b0};
            len = 11;
         end else begin
            exp = {1'b0, 1'b1, VEC[i][9:2], 1'b0};
            len = 10;
         end
         run_frame(int'(VEC[i][28:13]), VEC[i][9:2], len, exp);
      end

      // R7 R9: queued character follows with no gap; write during not-ready dropped
      begin
         logic [19:0] cap = '0;
         @(negedge clk); div_val = 16'd1; par_sel = 3'b100;
         wr_valid = 1'b1; wr_data = 8'h5A;
         @(negedge clk); wr_data = 8'h00;
         @(negedge clk); wr_data = 8'hC3;
         @(negedge clk); wr_valid = 1'b0;
         check("R7 second character held", {31'd0, hold_ready}, 32'd0);
         repeat (7) @(posedge clk);
         #1; cap[0] = txd;
         for (int j = 1; j < 20; j++) begin
            repeat (16) @(posedge clk);
            #1; cap[j] = txd;
         end
         check("R7 back-to-back frames", {12'd0, cap}, {12'd0, 1'b1, 8'hC3, 1'b0, 1'b1, 8'h5A, 1'b0});
         repeat (7) @(posedge clk);
         #1;
         check("R8 empty low until second stop ends", {31'd0, tx_empty}, 32'd0);
         @(posedge clk); #1;
         check("R8 empty after both frames", {31'd0, tx_empty}, 32'd1);
         count_lows(200, lows);
         check("R9 not-ready write not sent", lows, 32'd0);
      end

      // R5: zero divisor freezes a frame
      @(negedge clk); div_val = 16'd0;
      wr_valid = 1'b1; wr_data = 8'hF0;
      @(negedge clk); wr_valid = 1'b0;
      repeat (100) @(posedge clk);
      #1;
      check("R5 line frozen on start bit", {31'd0, txd}, 32'd0);
      check("R5 frame not finished", {31'd0, tx_empty}, 32'd0);
      @(negedge clk); div_val = 16'd1;
      repeat (200) @(posedge clk);
      #1;
      check("R5 frame resumes and completes", {31'd0, tx_empty}, 32'd1);

      // R10: abort mid-frame
      @(negedge clk); div_val = 16'd2; par_sel = 3'b000;
      wr_valid = 1'b1; wr_data = 8'h00;
      @(negedge clk); wr_valid = 1'b0;
      repeat (50) @(posedge clk);
      pulse_ctrl(1'b1, 1'b0);
      #1;
      check("R10 line high after abort", {31'd0, txd}, 32'd1);
      check("R10 ready low after abort", {31'd0, hold_ready}, 32'd0);
      check("R10 empty low after abort", {31'd0, tx_empty}, 32'd0);
      pulse_ctrl(1'b1, 1'b1);
      #1;
      check("R10 reset wins over enable", {31'd0, hold_ready}, 32'd0);
      pulse_ctrl(1'b0, 1'b1);
      #1;
      check("R10 re-enable ready", {31'd0, hold_ready}, 32'd1);
      check("R10 re-enable empty", {31'd0, tx_empty}, 32'd1);
      count_lows(300, lows);
      check("R10 aborted frame not resumed", lows, 32'd0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule